// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block lets a scheduler move a load above earlier stores without losing memory ordering. When a load is hoisted and issued early, its word address, byte mask and destination register tag go into a small associative table. Every store that follows compares its word address and byte mask with each valid entry. Any byte overlap marks that entry as violated.

At the load's original place in the program, a check operation looks up the entry by register tag. The response arrives one cycle later. It either lets the hoisted value stand or asks for the load to be executed again. A missing entry also asks for re-execution, because the load's record may have been evicted.

Within one cycle the three operations take effect in a fixed order: insert first, then the store search, then the check. A store issued in the same cycle as an insert therefore sees the new entry. A check in the same cycle sees both of them.

Top module: `hoist_ld_table`

## Requirements
- R1: After reset no response is signalled and the table holds no entries, so the first check of any tag asks for re-execution.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `chk_valid` high. `rsp_reexec` is low whenever `rsp_valid` is low.
- R3: A check of a tag that was inserted earlier, with no conflicting store since the insert, returns `rsp_reexec` = 0.
- R4: A store to the same word address whose byte mask (bit k = byte k of the word) shares at least one set bit with the entry's mask marks the entry violated. A later check of that tag returns `rsp_reexec` = 1.
- R5: A store to the same word with a disjoint byte mask, or to a different word, leaves the entry clean.
- R6: A check of a tag with no valid entry returns `rsp_reexec` = 1.
- R7: An insert whose tag is already in the table overwrites that entry's address and mask and clears its violation mark. Valid entries never share a tag.
- R8: A check that finds its tag removes the entry, whatever the outcome. A second check of the same tag returns `rsp_reexec` = 1.
- R9: An insert of a new tag takes the lowest-numbered free slot. When no slot is free, it evicts the slot named by a round-robin pointer. The pointer starts at slot 0 and advances only when an eviction happens.
- R10: A store in the same cycle as an insert with an overlapping address marks the new entry violated.
- R11: A store in the same cycle as a check is applied before the check.
- R12: A check in the same cycle as an insert of the same tag sees the new entry and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Hoisted load issues this cycle |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Word address of the load |
| ld_mask | input | BYTE_W | Bytes of the word the load reads |
| st_valid | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_mask | input | BYTE_W | Bytes of the word the store writes |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| rsp_valid | output | 1 | Check response valid (one cycle after check) |
| rsp_reexec | output | 1 | Load must be executed again |

## Verification
The bench builds the table with 4 entries, 5-bit tags, 12-bit word addresses and 4-byte masks. With only four slots, a fifth distinct tag forces an eviction. This reaches both the free-slot path and the round-robin path, including a pointer that has already moved. In the random phase, tags are drawn from 8 values and addresses from 4 words. Store conflicts, partial byte overlaps, same-cycle insert/store/check mixes and evicted-tag checks therefore happen often, and each one is compared against the behavioural model.

// File: rtl/hlt_pkg.sv
// Package: shared types for the hoisted-load conflict table.
// Assumes: nothing beyond standard SystemVerilog.
package hlt_pkg;
    // Where an inserted load is placed.
    typedef enum logic [1:0] {
        VIC_REUSE = 2'd0,   // tag already present: overwrite that slot
        VIC_FREE  = 2'd1,   // lowest free slot
        VIC_EVICT = 2'd2    // table full: round-robin victim
    } vic_src_e;
endpackage

// File: rtl/hlt_entry.sv
// One table slot. It holds tag, word address, byte mask, a valid bit and a
// violation bit. It also produces the slot's effective state for this cycle,
// after this cycle's insert and store, so the check logic can read it.
// Assumes: wr_en and clr_en refer to the same cycle as the store inputs.
module hlt_entry #(
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_mask,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [BYTE_W-1:0] st_mask,
    input  logic              clr_en,
    output logic              q_valid,
    output logic [TAG_W-1:0]  q_tag,
    output logic              eff_valid,
    output logic              eff_viol,
    output logic [TAG_W-1:0]  eff_tag
);
    logic              valid_q, viol_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q, eff_addr;
    logic [BYTE_W-1:0] mask_q, eff_mask;
    logic              conflict;

    assign q_valid = valid_q;
    assign q_tag   = tag_q;

    // Effective slot contents: an insert wins first, then the store search.
    always_comb begin
        eff_valid = valid_q | wr_en;
        eff_tag   = wr_en ? wr_tag  : tag_q;
        eff_addr  = wr_en ? wr_addr : addr_q;
        eff_mask  = wr_en ? wr_mask : mask_q;
        conflict  = st_valid && eff_valid && (eff_addr == st_addr)
                    && ((eff_mask & st_mask) != '0);
        eff_viol  = (wr_en ? 1'b0 : viol_q) | conflict;
    end

    // Slot state register; a check hit clears the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            viol_q  <= 1'b0;
            tag_q   <= '0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            valid_q <= eff_valid & ~clr_en;
            viol_q  <= eff_viol;
            if (wr_en) begin
                tag_q  <= wr_tag;
                addr_q <= wr_addr;
                mask_q <= wr_mask;
            end
        end
    end
endmodule

// File: rtl/hlt_victim.sv
// Chooses the slot for an inserted load. The order of preference is: the
// slot already holding the tag, then the lowest free slot, then the
// round-robin pointer. The pointer moves only on an eviction.
// Assumes: valid slots never share a tag (the reuse path keeps this true).
module hlt_victim #(
    parameter int N_ENT = 4,
    parameter int TAG_W = 5,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_valid,
    input  logic [TAG_W-1:0]            ld_tag,
    input  logic [N_ENT-1:0]            q_valid,
    input  logic [N_ENT-1:0][TAG_W-1:0] q_tag,
    output logic [N_ENT-1:0]            wr_oh,
    output logic [IDX_W-1:0]            rr_ptr
);
    import hlt_pkg::*;

    logic [IDX_W-1:0] rr_q, idx;
    vic_src_e         src;

    assign rr_ptr = rr_q;

    // Select the victim slot by preference order.
    always_comb begin
        src = VIC_EVICT;
        idx = rr_q;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!q_valid[i]) begin
                src = VIC_FREE;
                idx = IDX_W'(i);
            end
        end
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (q_valid[i] && (q_tag[i] == ld_tag)) begin
                src = VIC_REUSE;
                idx = IDX_W'(i);
            end
        end
    end

    // Write enable for the chosen slot.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            wr_oh[i] = ld_valid && (idx == IDX_W'(i));
        end
    end

    // Round-robin pointer, advanced on each eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (ld_valid && (src == VIC_EVICT)) begin
            rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/hlt_check.sv
// Tag lookup for the check operation. It runs against each slot's effective
// state, so this cycle's insert and store are already visible. It returns
// the re-execute decision and the slot to invalidate.
// Assumes: at most one effective entry matches a tag.
module hlt_check #(
    parameter int N_ENT = 4,
    parameter int TAG_W = 5
) (
    input  logic                        chk_valid,
    input  logic [TAG_W-1:0]            chk_tag,
    input  logic [N_ENT-1:0]            eff_valid,
    input  logic [N_ENT-1:0]            eff_viol,
    input  logic [N_ENT-1:0][TAG_W-1:0] eff_tag,
    output logic [N_ENT-1:0]            clr_oh,
    output logic                        reexec
);
    logic [N_ENT-1:0] hit_vec;

    // Match the tag in every slot; any miss or violation forces re-execution.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            hit_vec[i] = eff_valid[i] && (eff_tag[i] == chk_tag);
        end
        clr_oh = chk_valid ? hit_vec : '0;
        reexec = (hit_vec == '0) || ((hit_vec & eff_viol) != '0);
    end
endmodule

// File: rtl/hoist_ld_table.sv
// Top of the hoisted-load conflict table. Inserts, store searches and checks
// all take effect in one cycle, in the order insert, store, check. The check
// response is registered and appears one cycle later.
// Assumes: a word address plus byte mask fully describes each access.
module hoist_ld_table #(
    parameter int N_ENT  = 4,
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTE_W-1:0] ld_mask,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [BYTE_W-1:0] st_mask,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              rsp_valid,
    output logic              rsp_reexec
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0]            q_valid, eff_valid, eff_viol, wr_oh, clr_oh;
    logic [N_ENT-1:0][TAG_W-1:0] q_tag, eff_tag;
    logic [IDX_W-1:0]            rr_ptr;
    logic                        reexec_now;
    logic                        rsp_valid_q, rsp_reexec_q;

    hlt_victim #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_tag   (ld_tag),
        .q_valid  (q_valid),
        .q_tag    (q_tag),
        .wr_oh    (wr_oh),
        .rr_ptr   (rr_ptr)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        hlt_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_oh[g]),
            .wr_tag    (ld_tag),
            .wr_addr   (ld_addr),
            .wr_mask   (ld_mask),
            .st_valid  (st_valid),
            .st_addr   (st_addr),
            .st_mask   (st_mask),
            .clr_en    (clr_oh[g]),
            .q_valid   (q_valid[g]),
            .q_tag     (q_tag[g]),
            .eff_valid (eff_valid[g]),
            .eff_viol  (eff_viol[g]),
            .eff_tag   (eff_tag[g])
        );
    end

    hlt_check #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_check (
        .chk_valid (chk_valid),
        .chk_tag   (chk_tag),
        .eff_valid (eff_valid),
        .eff_viol  (eff_viol),
        .eff_tag   (eff_tag),
        .clr_oh    (clr_oh),
        .reexec    (reexec_now)
    );

    // Register the check response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q  <= 1'b0;
            rsp_reexec_q <= 1'b0;
        end else begin
            rsp_valid_q  <= chk_valid;
            rsp_reexec_q <= chk_valid & reexec_now;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_reexec = rsp_reexec_q;
endmodule

// File: rtl/hlt_checker.sv
// Property checker for hoist_ld_table, attached by bind below. It watches
// the ports, slot valid bits, slot tags and the round-robin pointer.
module hlt_checker #(
    parameter int N_ENT  = 4,
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ld_valid,
    input logic [TAG_W-1:0]            ld_tag,
    input logic [ADDR_W-1:0]           ld_addr,
    input logic [BYTE_W-1:0]           ld_mask,
    input logic                        st_valid,
    input logic [ADDR_W-1:0]           st_addr,
    input logic [BYTE_W-1:0]           st_mask,
    input logic                        chk_valid,
    input logic [TAG_W-1:0]            chk_tag,
    input logic                        rsp_valid,
    input logic                        rsp_reexec,
    input logic [N_ENT-1:0]            q_valid,
    input logic [N_ENT-1:0][TAG_W-1:0] q_tag,
    input logic [IDX_W-1:0]            rr_ptr
);
    logic dup;

    // Flag any pair of valid slots holding the same tag.
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            for (int j = i + 1; j < N_ENT; j++) begin
                if (q_valid[i] && q_valid[j] && (q_tag[i] == q_tag[j])) dup = 1'b1;
            end
        end
    end

    // Response follows every check by one cycle.
    assert_rsp_follows_chk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);
    assert_no_rsp_no_reexec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_reexec);

    // Pointer stays within the table.
    assert_rr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rr_ptr <= IDX_W'(N_ENT - 1));

    // Check right after a clean insert of the same tag keeps the hoisted value.
    assert_clean_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !ld_valid && !st_valid && $past(rst_n) && $past(ld_valid)
         && !$past(st_valid) && !$past(chk_valid) && (chk_tag == $past(ld_tag)))
        |=> !rsp_reexec);

    // Same-cycle insert and overlapping store leaves a violated entry.
    assert_same_cycle_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !ld_valid && $past(rst_n) && (chk_tag == $past(ld_tag))
         && $past(ld_valid && st_valid && (st_addr == ld_addr)
                  && ((st_mask & ld_mask) != '0)))
        |=> rsp_reexec);

    // Valid slots never share a tag.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_unique_tags_R7: assert (!dup)
                else $error("duplicate tag in table");
        end
    end
endmodule

bind hoist_ld_table hlt_checker #(
    .N_ENT(N_ENT), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
) u_hlt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_tag     (ld_tag),
    .ld_addr    (ld_addr),
    .ld_mask    (ld_mask),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .st_mask    (st_mask),
    .chk_valid  (chk_valid),
    .chk_tag    (chk_tag),
    .rsp_valid  (rsp_valid),
    .rsp_reexec (rsp_reexec),
    .q_valid    (q_valid),
    .q_tag      (q_tag),
    .rr_ptr     (rr_ptr)
);

// File: tb/tb_hoist_ld_table.sv
// Bench for hoist_ld_table. A behavioural model, run once per cycle, predicts
// rsp_valid and rsp_reexec, and the bench compares them after every clock.
module tb_hoist_ld_table;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT  = 4;
    localparam int TAG_W  = 5;
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
    logic [TAG_W-1:0]  ld_tag = '0, chk_tag = '0;
    logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
    logic [BYTE_W-1:0] ld_mask = '0, st_mask = '0;
    logic              rsp_valid, rsp_reexec;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state
    bit m_valid [N_ENT];
    bit m_viol  [N_ENT];
    int m_tag   [N_ENT];
    int m_addr  [N_ENT];
    int m_mask  [N_ENT];
    int m_rr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hoist_ld_table #(.N_ENT(N_ENT), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_mask(ld_mask),
        .st_valid(st_valid), .st_addr(st_addr), .st_mask(st_mask),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .rsp_valid(rsp_valid), .rsp_reexec(rsp_reexec)
    );

    task automatic model_clear();
        for (int i = 0; i < N_ENT; i++) begin
            m_valid[i] = 0; m_viol[i] = 0; m_tag[i] = 0; m_addr[i] = 0; m_mask[i] = 0;
        end
        m_rr = 0;
    endtask

    task automatic compare(input bit exp_v, input bit exp_r, input string req);
        n_checks++;
        if (rsp_valid !== exp_v || rsp_reexec !== exp_r) begin
            n_fail++;
            $display("FAIL %s: rsp_valid/rsp_reexec = %b/%b, expected %b/%b",
                     req, rsp_valid, rsp_reexec, exp_v, exp_r);
        end
    endtask

    // One cycle: drive, update the model in program order, then compare.
    task automatic step(input bit ld, input int lt, input int la, input int lm,
                        input bit st, input int sa, input int sm,
                        input bit ck, input int ct, input string req);
        int  v;
        bit  found;
        bit  exp_r;
        @(negedge clk);
        ld_valid = ld; ld_tag = TAG_W'(lt); ld_addr = ADDR_W'(la); ld_mask = BYTE_W'(lm);
        st_valid = st; st_addr = ADDR_W'(sa); st_mask = BYTE_W'(sm);
        chk_valid = ck; chk_tag = TAG_W'(ct);
        if (ld) begin
            found = 0; v = 0;
            for (int i = 0; i < N_ENT; i++)
                if (!found && m_valid[i] && m_tag[i] == lt) begin found = 1; v = i; end
            for (int i = 0; i < N_ENT; i++)
                if (!found && !m_valid[i]) begin found = 1; v = i; end
            if (!found) begin v = m_rr; m_rr = (m_rr + 1) % N_ENT; end
            m_valid[v] = 1; m_viol[v] = 0; m_tag[v] = lt; m_addr[v] = la; m_mask[v] = lm;
        end
        if (st) begin
            for (int i = 0; i < N_ENT; i++)
                if (m_valid[i] && m_addr[i] == sa && (m_mask[i] & sm) != 0) m_viol[i] = 1;
        end
        exp_r = 0;
        if (ck) begin
            found = 0;
            for (int i = 0; i < N_ENT; i++)
                if (!found && m_valid[i] && m_tag[i] == ct) begin
                    found = 1; exp_r = m_viol[i]; m_valid[i] = 0;
                end
            if (!found) exp_r = 1;
        end
        @(posedge clk);
        #1;
        compare(ck, exp_r, req);
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        ld_valid = 0; st_valid = 0; chk_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        compare(0, 0, "R1");
        model_clear();
        @(negedge clk);
        rst_n = 1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1: empty table after reset, first check re-executes
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, "R2");
        idle("R1");
        // R3: clean insert then check
        step(1, 1, 16, 4'hF, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R3");
        // R4: overlapping store on one byte
        step(1, 2, 20, 4'b0011, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 20, 4'b0010, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2, "R4");
        // R5: disjoint mask and different word leave entry clean
        step(1, 3, 24, 4'b0011, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 24, 4'b1100, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 25, 4'b1111, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, "R5");
        // R6: unknown tag
        step(0, 0, 0, 0, 0, 0, 0, 1, 9, "R6");
        // R7: re-insert same tag clears violation, uses new address
        step(1, 4, 30, 4'hF, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 30, 4'h1, 0, 0, "R7");
        step(1, 4, 31, 4'hF, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 30, 4'hF, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, 4, "R7");
        // R8: check consumes the entry
        step(1, 5, 40, 4'hF, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 5, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 5, "R8");
        // R10: same-cycle insert and overlapping store
        step(1, 6, 50, 4'b0100, 1, 50, 4'b0110, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 1, 6, "R10");
        // R11: same-cycle store and check
        step(1, 7, 60, 4'hF, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 1, 60, 4'h8, 1, 7, "R11");
        // R12: same-cycle insert and check of one tag
        step(1, 8, 70, 4'hF, 0, 0, 0, 1, 8, "R12");
        step(0, 0, 0, 0, 0, 0, 0, 1, 8, "R12");
        idle("R2");
        // R9: fill, evict round-robin, refill free slot, evict again
        do_reset();
        for (int t = 10; t < 14; t++) step(1, t, t, 4'hF, 0, 0, 0, 0, 0, "R9");
        step(1, 14, 14, 4'hF, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 10, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 11, "R9");
        step(1, 15, 15, 4'hF, 0, 0, 0, 0, 0, "R9");
        step(1, 16, 16, 4'hF, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 15, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 12, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 14, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 16, "R9");
        // Random mix against the model
        for (int k = 0; k < 3000; k++) begin
            step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom_range(1, 15), $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(1, 15), $urandom_range(0, 1), $urandom_range(0, 7),
                 "random mix");
        end
        idle("R2");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule